// File: doc/BRIEF.md
# Scatter-Gather to Region Descriptor Segmenter

This block turns a request made of scatter-gather segments into a stream of physical region descriptor entries for a bus-master DMA engine. Each input segment is a 32-bit bus address and a 32-bit byte length. Each output entry is a 32-bit base address and a 32-bit count word. Segments are cut so that no entry crosses a 64 KiB address boundary. In the standard layout, a chunk of exactly 64 KiB is emitted as two 32 KiB entries, because some controllers read a zero count as zero bytes. The final entry of a request carries an end-of-table flag.

A format input selects an alternate count encoding for one nonstandard controller. The block holds the most recent entry back by one position, so that it can still flag that entry as final when the request ends. When a request would need more entries than the table allows, the block reports an overflow. The driver then falls back to programmed I/O for that request. A request that yields no entries is reported as empty. Every request ends with a one-cycle `done` pulse and an entry total.

Top module: `prd_segmenter`

## Requirements
- R1: Each chunk taken from a segment has a byte size equal to the smaller of (0x10000 minus address bits 15:0) and the remaining segment length. The address and the remaining length then advance by the bytes emitted, so no entry crosses a 64 KiB boundary.
- R2: In the standard layout, the count word holds the byte count in bits 15:0, and bits 30:16 are zero.
- R3: In the standard layout, a chunk of exactly 0x10000 bytes is emitted as two entries with count 0x8000: first at the chunk address, then at the chunk address plus 0x8000.
- R4: In the standard layout, bit 31 of the count word is 1 on the final entry of a request and 0 on every other entry.
- R5: When `alt_fmt` is 1, the count word is ((bytes >> 2) - 1) << 16, computed modulo 2^32. Chunks of 64 KiB are not split, and no end-of-table bit is added.
- R6: If a request would need entry number MAX_ENTRIES+1, the request fails. The block does the following:
  - it consumes the rest of the request's segments, through the one marked last;
  - it pulses `done` with `err_overflow` = 1;
  - it reports `ent_total` = 0.
  A request of exactly MAX_ENTRIES entries succeeds.
- R7: A request that produces no entries ends with `done` and `err_empty` = 1, and emits no entry.
- R8: Zero-length segments are consumed and produce no entries.
- R9: On success, `done` pulses one cycle after the final entry's output handshake, with `ent_total` equal to the number of entries emitted.
- R10: While `ent_valid` is 1 and `ent_ready` is 0, `ent_valid`, `ent_addr` and `ent_word` hold their values.
- R11: After reset, `ent_valid` is 0, `done` is 0 and `seg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_fmt | input | 1 | 1 selects the alternate count encoding; held constant during a request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when valid and ready are both 1 |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Marks the final segment of a request |
| ent_valid | output | 1 | Entry offered |
| ent_ready | input | 1 | Consumer takes the entry |
| ent_addr | output | 32 | Entry base address |
| ent_word | output | 32 | Entry count/flag word |
| done | output | 1 | One-cycle pulse at the end of a request |
| err_overflow | output | 1 | With `done`: the entry limit was exceeded |
| err_empty | output | 1 | With `done`: the request produced no entries |
| ent_total | output | CNT_W | Entries emitted, valid from `done` until the next `done` |

## Verification
Two things can happen in the same clock edge:
- the held entry moves into the output register;
- a freshly cut chunk takes its place in the hold register.

When the consumer stalls, this pairing is delayed, and the output must stay frozen. The bench provokes this case by pulsing `ent_ready` low in a repeating pattern while multi-entry requests run. It judges the outcome in two ways:
- every stalled cycle must show an unchanged entry;
- the collected sequence must match the independently modelled entry list, in order.

A second collision occurs when overflow is detected on a chunk of the segment marked last. The bench then expects `done` and the error together, with no end-of-table entry.

// File: rtl/prd_segmenter.sv
module prd_segmenter #(
  parameter int MAX_ENTRIES = 256,
  parameter int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_fmt,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [31:0]      seg_len,
  input  logic             seg_last,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [31:0]      ent_addr,
  output logic [31:0]      ent_word,
  output logic             done,
  output logic             err_overflow,
  output logic             err_empty,
  output logic [CNT_W-1:0] ent_total
);

  typedef enum logic [2:0] {S_IN, S_RUN, S_END, S_WAIT, S_DRAIN} st_t;
  st_t st;

  logic [31:0]      cur_a, cur_l;
  logic             cur_last;
  logic             hold_v, hold_alt, out_alt;
  logic [31:0]      hold_a, hold_w;
  logic [CNT_W-1:0] cnt;

  wire [16:0] room     = 17'h10000 - {1'b0, cur_a[15:0]};
  wire [31:0] chunk    = ({15'b0, room} > cur_l) ? cur_l : {15'b0, room};
  wire        full     = !alt_fmt && (chunk == 32'h10000);
  wire [31:0] step     = full ? 32'h8000 : chunk;
  wire [31:0] alt_w    = ((chunk >> 2) - 32'd1) << 16;
  wire [31:0] new_w    = alt_fmt ? alt_w : {16'h0, step[15:0]};
  wire        out_free = !ent_valid || ent_ready;
  wire        gen      = (st == S_RUN) && (!hold_v || out_free);
  wire        at_max   = (cnt == CNT_W'(MAX_ENTRIES));
  wire        seg_fire = seg_valid && seg_ready;

  assign seg_ready = (st == S_IN) || (st == S_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IN;
      cur_a <= '0; cur_l <= '0; cur_last <= 1'b0;
      hold_v <= 1'b0; hold_a <= '0; hold_w <= '0; hold_alt <= 1'b0;
      ent_valid <= 1'b0; ent_addr <= '0; ent_word <= '0; out_alt <= 1'b0;
      cnt <= '0; done <= 1'b0; err_overflow <= 1'b0; err_empty <= 1'b0;
      ent_total <= '0;
    end else begin
      done <= 1'b0;
      err_overflow <= 1'b0;
      err_empty <= 1'b0;
      if (ent_valid && ent_ready) ent_valid <= 1'b0;
      case (st)
        S_IN: if (seg_fire) begin
          cur_a <= seg_addr;
          cur_l <= seg_len;
          cur_last <= seg_last;
          if (seg_len != 0) st <= S_RUN;
          else if (seg_last) st <= S_END;
        end
        S_RUN: if (gen) begin
          if (at_max) begin
            hold_v <= 1'b0;
            cnt <= '0;
            if (cur_last) begin
              done <= 1'b1; err_overflow <= 1'b1; ent_total <= '0;
              st <= S_IN;
            end else st <= S_DRAIN;
          end else begin
            if (hold_v) begin
              ent_valid <= 1'b1;
              ent_addr <= hold_a;
              ent_word <= hold_w;
              out_alt <= hold_alt;
            end
            hold_v <= 1'b1;
            hold_a <= cur_a;
            hold_w <= new_w;
            hold_alt <= alt_fmt;
            cnt <= cnt + 1'b1;
            cur_a <= cur_a + step;
            cur_l <= cur_l - step;
            if (cur_l == step) st <= cur_last ? S_END : S_IN;
          end
        end
        S_END: begin
          if (!hold_v) begin
            done <= 1'b1; err_empty <= 1'b1; ent_total <= '0; cnt <= '0;
            st <= S_IN;
          end else if (out_free) begin
            ent_valid <= 1'b1;
            ent_addr <= hold_a;
            ent_word <= hold_alt ? hold_w : (hold_w | 32'h8000_0000);
            out_alt <= hold_alt;
            hold_v <= 1'b0;
            st <= S_WAIT;
          end
        end
        S_WAIT: if (ent_valid && ent_ready) begin
          done <= 1'b1; ent_total <= cnt; cnt <= '0;
          st <= S_IN;
        end
        S_DRAIN: if (seg_fire && seg_last) begin
          done <= 1'b1; err_overflow <= 1'b1; ent_total <= '0;
          st <= S_IN;
        end
        default: st <= S_IN;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_addr) && $stable(ent_word)); // R10
  AST_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !out_alt |-> ({1'b0, ent_addr[15:0]} + {1'b0, ent_word[15:0]}) <= 17'h10000); // R1
  AST_STD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !out_alt |-> ent_word[15:0] != 16'h0 && ent_word[30:16] == 15'h0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_ENTRIES)); // R6
  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow || err_empty) |-> done && !(err_overflow && err_empty)); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err_overflow && !err_empty |-> $past(ent_valid && ent_ready)); // R9

endmodule

// File: tb/tb_prd_segmenter.sv
module tb_prd_segmenter;
  localparam int MAXE = 8;
  localparam int CW = $clog2(MAXE + 1);

  logic clk = 0, rst_n = 0, alt_fmt = 0;
  logic seg_valid = 0, seg_last = 0, ent_ready = 1;
  logic [31:0] seg_addr = 0, seg_len = 0;
  logic seg_ready, ent_valid, done, err_overflow, err_empty;
  logic [31:0] ent_addr, ent_word;
  logic [CW-1:0] ent_total;

  prd_segmenter #(.MAX_ENTRIES(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .alt_fmt(alt_fmt),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr),
    .ent_word(ent_word), .done(done), .err_overflow(err_overflow),
    .err_empty(err_empty), .ent_total(ent_total));

  always #5 clk = ~clk;

  int vec_n = 0, miss = 0;
  logic [31:0] got_a [0:63], got_w [0:63], exp_a [0:63], exp_w [0:63];
  int got_n = 0, exp_n = 0, done_n = 0, ncyc = 0, acc_cyc = 0, done_cyc = 0;
  bit stall_en = 0, d_ovf = 0, d_emp = 0, pv = 0;
  logic [CW-1:0] d_tot = 0;
  logic [31:0] pa = 0, pw = 0;

  localparam logic [95:0] VEC [8] = '{
    {32'h0000_1000, 32'h0000_0800, 16'd1, 16'd0},
    {32'h0001_F000, 32'h0000_2000, 16'd2, 16'd0},
    {32'h0002_0000, 32'h0001_0000, 16'd2, 16'd0},
    {32'h0003_8000, 32'h0001_8000, 16'd3, 16'd0},
    {32'h0004_0000, 32'h0001_0000, 16'd1, 16'd1},
    {32'h0005_C000, 32'h0000_8000, 16'd2, 16'd1},
    {32'h0000_0002, 32'h0000_0003, 16'd1, 16'd0},
    {32'h0006_0000, 32'h0000_0002, 16'd1, 16'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ncyc++;
    ent_ready = stall_en ? (ncyc % 3 != 1) : 1'b1;
    if (pv) chk(ent_valid && ent_addr == pa && ent_word == pw, "R10 stall hold", ent_word, pw);
    pv = ent_valid && !ent_ready;
    pa = ent_addr; pw = ent_word;
    if (ent_valid && ent_ready && got_n < 64) begin
      got_a[got_n] = ent_addr; got_w[got_n] = ent_word; got_n++; acc_cyc = ncyc;
    end
    if (done) begin
      done_n++; d_ovf = err_overflow; d_emp = err_empty; d_tot = ent_total; done_cyc = ncyc;
    end
  end

  task automatic push(input logic [31:0] a, input logic [31:0] w);
    exp_a[exp_n] = a; exp_w[exp_n] = w; exp_n++;
  endtask

  task automatic model_seg(input bit alt, input logic [31:0] a0, input logic [31:0] l0);
    logic [31:0] a, l, bc;
    a = a0; l = l0;
    while (l != 0) begin
      bc = 32'h10000 - {16'h0, a[15:0]};
      if (bc > l) bc = l;
      if (alt) push(a, ((bc >> 2) - 32'd1) << 16);
      else if (bc == 32'h10000) begin push(a, 32'h8000); push(a + 32'h8000, 32'h8000); end
      else push(a, bc);
      a = a + bc; l = l - bc;
    end
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input bit last);
    seg_addr = a; seg_len = l; seg_last = last; seg_valid = 1;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 0;
  endtask

  task automatic start_req();
    got_n = 0; exp_n = 0; done_n = 0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done_n == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string tag, input bit alt);
    if (!alt && exp_n > 0) exp_w[exp_n-1] = exp_w[exp_n-1] | 32'h8000_0000;
    chk(done_n == 1, {tag, " done count"}, done_n, 1);
    chk(!d_ovf && !d_emp, {tag, " no error"}, {d_ovf, d_emp}, 0);
    chk(got_n == exp_n, {tag, " entry count"}, got_n, exp_n);
    chk(int'(d_tot) == exp_n, {"R9 ", tag, " total"}, d_tot, exp_n);
    chk(done_cyc == acc_cyc + 1, {"R9 ", tag, " done timing"}, done_cyc, acc_cyc + 1);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_a[i] == exp_a[i], {tag, " addr"}, got_a[i], exp_a[i]);
      chk(got_w[i] == exp_w[i], {tag, " word"}, got_w[i], exp_w[i]);
    end
  endtask

  initial begin
    #1000000;
    miss++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ent_valid && !done && seg_ready, "R11 reset", {ent_valid, done, seg_ready}, 3'b001);
    rst_n = 1;
    @(negedge clk);
    chk(!ent_valid && !done && seg_ready, "R11 after reset", {ent_valid, done, seg_ready}, 3'b001);

    // R1 R2 R3 R4 R5: single-segment vector table
    for (int i = 0; i < 8; i++) begin
      logic [95:0] v;
      v = VEC[i];
      start_req();
      alt_fmt = v[0];
      model_seg(v[0], v[95:64], v[63:32]);
      chk(exp_n == int'(v[31:16]), "R1 R3 R5 table count", exp_n, v[31:16]);
      send_seg(v[95:64], v[63:32], 1);
      wait_done();
      compare(v[0] ? "R5 vec" : "R1 R2 R3 R4 vec", v[0]);
    end

    // R8 R4: zero-length segment in the middle, with stalled consumer (R10)
    alt_fmt = 0; stall_en = 1;
    start_req();
    model_seg(0, 32'h0001_0000, 32'h100);
    model_seg(0, 32'h0002_FFF0, 32'h20);
    send_seg(32'h0001_0000, 32'h100, 0);
    send_seg(32'h0050_0000, 32'h0, 0);
    send_seg(32'h0002_FFF0, 32'h20, 1);
    wait_done();
    compare("R8 R4 multi", 0);
    chk(got_w[1][31] == 1'b0, "R4 non-final no eot", got_w[1], 0);

    // R10: long stalled request with splits
    start_req();
    model_seg(0, 32'h0010_4000, 32'h0002_C000);
    send_seg(32'h0010_4000, 32'h0002_C000, 1);
    wait_done();
    compare("R10 R3 stalled", 0);
    stall_en = 0;

    // R7: empty request
    start_req();
    send_seg(32'h0, 32'h0, 1);
    wait_done();
    chk(done_n == 1 && d_emp && !d_ovf, "R7 empty error", {d_emp, d_ovf}, 2'b10);
    chk(got_n == 0, "R7 no entries", got_n, 0);

    // R6: exactly MAX entries succeeds
    start_req();
    model_seg(0, 32'h0, 32'h0004_0000);
    send_seg(32'h0, 32'h0004_0000, 1);
    wait_done();
    compare("R6 exact limit", 0);

    // R6: overflow with drain of trailing segment
    start_req();
    send_seg(32'h0, 32'h0005_0000, 0);
    send_seg(32'h0010_0000, 32'h10, 1);
    wait_done();
    chk(done_n == 1 && d_ovf && !d_emp, "R6 overflow flag", {d_ovf, d_emp}, 2'b10);
    chk(d_tot == 0, "R6 overflow total", d_tot, 0);
    chk(got_n == MAXE - 1, "R6 entries before failure", got_n, MAXE - 1);
    chk(seg_ready, "R6 ready after drain", seg_ready, 1);

    // R6: overflow detected on last segment
    start_req();
    send_seg(32'h0, 32'h0005_0000, 1);
    wait_done();
    chk(done_n == 1 && d_ovf, "R6 overflow on last", d_ovf, 1);

    // recovery after overflow
    start_req();
    model_seg(0, 32'h0000_8000, 32'h10);
    send_seg(32'h0000_8000, 32'h10, 1);
    wait_done();
    compare("R9 after overflow", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss);
    $finish;
  end
endmodule